// File: doc/BRIEF.md
# SEU Shift-Chain Test Harness

This block is a self-contained fixture for single-event-upset experiments on a long serial shift chain. A source shifts one pattern bit per clock into the chain. The pattern is selectable as constant ones, constant zeros or an alternating 1/0 checkerboard. A monitor rebuilds the bit it expects at the far end of the chain from the same pattern rule, with a phase offset equal to the chain length. It compares that bit with the chain output on every clock.

Every mismatch raises a one-cycle error pulse and advances a saturating error counter. A run of consecutive mismatches longer than a programmable threshold is reported as a burst, and bursts have their own counter. The two error classes show up differently. A flipped storage bit gives one isolated error as it leaves the chain. A lost or extra shift clock moves the phase of everything in flight, which gives a run of errors as long as the chain.

Four injection inputs let a simulation create both classes: invert one chosen stage, hold the chain for one clock, or shift it twice in one clock. The pattern select and the threshold are expected to change only while reset is held.

Top module: `seu_chain_harness`

## Requirements
- R1: The pattern select encodes 2'b00 as constant one, 2'b01 as constant zero, and 2'b10 or 2'b11 as checkerboard. One bit enters the chain per clock, and with no injection no error is ever reported.
- R2: For the first CHAIN_LEN clocks after reset is released no comparison is made, so err_pulse stays low and err_count stays zero.
- R3: A mismatch at the chain end raises err_pulse for exactly one cycle on the next clock. A stage i inverted at clock edge E gives err_pulse after edge E+CHAIN_LEN-i.
- R4: err_count increments by exactly one for each cycle err_pulse is high and is otherwise stable.
- R5: err_count and burst_count hold at all ones instead of wrapping.
- R6: A single inverted stage gives exactly one error under any pattern and no burst while burst_thresh is at least 1.
- R7: With the checkerboard pattern, one held shift gives exactly CHAIN_LEN consecutive errors, and one doubled shift gives exactly CHAIN_LEN-1 consecutive errors.
- R8: With either constant pattern, held or doubled shifts give no error.
- R9: burst_flag is high for each mismatch that extends a run beyond burst_thresh consecutive mismatches, and burst_count increments once per such run. A run of L mismatches therefore gives L-burst_thresh flagged cycles.
- R10: Synchronous active-high reset clears err_pulse, err_count, burst_flag and burst_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and compare clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 2 | Pattern choice: 00 ones, 01 zeros, 1x checkerboard |
| burst_thresh | input | TH_W | Run length that a burst must exceed |
| inj_flip | input | 1 | Invert stage inj_idx on this clock |
| inj_idx | input | IDX_W | Stage selected for inversion |
| inj_hold | input | 1 | Chain skips this shift (wins over inj_double) |
| inj_double | input | 1 | Chain shifts twice on this clock |
| err_pulse | output | 1 | One-cycle mismatch pulse |
| err_count | output | CNT_W | Saturating mismatch count |
| burst_flag | output | 1 | Mismatch lies beyond the burst threshold |
| burst_count | output | CNT_W | Saturating count of bursts |

## Verification
Every result is registered once after the compare. err_pulse, err_count, burst_flag and burst_count all change on the edge after the mismatching bit reaches the last stage. An inversion of stage i applied on edge E is therefore due after edge E+CHAIN_LEN-i, and the first possible pulse after reset comes CHAIN_LEN+1 edges after release. The bench drives inputs and samples outputs on the falling edge and numbers the samples after each injection edge. It compares the index of the first pulse with this latency, and it compares run lengths, flagged cycles and final counts against values derived from the chain length and threshold.

// File: rtl/seu_harness_pkg.sv
package seu_harness_pkg;

    typedef enum logic [1:0] {
        PAT_ONES  = 2'b00,
        PAT_ZEROS = 2'b01,
        PAT_ALT   = 2'b10,
        PAT_ALT_B = 2'b11
    } pat_e;

    typedef struct packed {
        logic hold;
        logic dbl;
    } shift_ctl_t;

    typedef struct packed {
        logic mis;
        logic over;
        logic first_over;
    } cmp_t;

    function automatic logic pat_bit(input logic [1:0] sel, input logic phase);
        logic b;
        case (pat_e'(sel))
            PAT_ONES:  b = 1'b1;
            PAT_ZEROS: b = 1'b0;
            default:   b = phase;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/seu_pattern_gen.sv
module seu_pattern_gen
    import seu_harness_pkg::*;
#(
    parameter int CHAIN_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pat_sel,
    output logic       src_bit,
    output logic       ref_bit
);
    localparam logic LAG_ODD = ((CHAIN_LEN % 2) == 1);

    logic phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    // The bit now leaving the chain entered CHAIN_LEN clocks ago.
    always_comb begin
        src_bit = pat_bit(pat_sel, phase);
        ref_bit = pat_bit(pat_sel, phase ^ LAG_ODD);
    end
endmodule

// File: rtl/seu_shift_chain.sv
module seu_shift_chain
    import seu_harness_pkg::*;
#(
    parameter int CHAIN_LEN = 16,
    parameter int IDX_W     = $clog2(CHAIN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  shift_ctl_t       ctl,
    input  logic             flip,
    input  logic [IDX_W-1:0] flip_idx,
    output logic             dout
);
    logic [CHAIN_LEN-1:0] stage_q;
    logic [CHAIN_LEN-1:0] shifted;
    logic [CHAIN_LEN-1:0] flip_mask;

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign shifted[k] = din;
        end else if (k == 1) begin : g_second
            assign shifted[k] = ctl.dbl ? din : stage_q[0];
        end else begin : g_body
            assign shifted[k] = ctl.dbl ? stage_q[k-2] : stage_q[k-1];
        end
        assign flip_mask[k] = flip && (flip_idx == IDX_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= (ctl.hold ? stage_q : shifted) ^ flip_mask;
    end

    assign dout = stage_q[CHAIN_LEN-1];
endmodule

// File: rtl/seu_mismatch_mon.sv
module seu_mismatch_mon
    import seu_harness_pkg::*;
#(
    parameter int CHAIN_LEN = 16,
    parameter int CNT_W     = 32,
    parameter int TH_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chain_bit,
    input  logic             ref_bit,
    input  logic [TH_W-1:0]  burst_thresh,
    output logic             err_pulse,
    output logic [CNT_W-1:0] err_count,
    output logic             burst_flag,
    output logic [CNT_W-1:0] burst_count
);
    localparam int WARM_W = $clog2(CHAIN_LEN + 1);
    localparam logic [WARM_W-1:0] WARM_END = WARM_W'(CHAIN_LEN);

    logic [WARM_W-1:0] warm_q;
    logic [TH_W:0]     run_q;
    cmp_t              cmp;

    always_comb begin
        cmp.mis        = (warm_q == WARM_END) && (chain_bit != ref_bit);
        cmp.over       = cmp.mis && (run_q >= {1'b0, burst_thresh});
        cmp.first_over = cmp.mis && (run_q == {1'b0, burst_thresh});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q      <= '0;
            run_q       <= '0;
            err_pulse   <= 1'b0;
            burst_flag  <= 1'b0;
            err_count   <= '0;
            burst_count <= '0;
        end else begin
            if (warm_q != WARM_END) warm_q <= warm_q + 1'b1;
            if (!cmp.mis)    run_q <= '0;
            else if (!(&run_q)) run_q <= run_q + 1'b1;
            err_pulse  <= cmp.mis;
            burst_flag <= cmp.over;
            if (cmp.mis && !(&err_count))          err_count   <= err_count + 1'b1;
            if (cmp.first_over && !(&burst_count)) burst_count <= burst_count + 1'b1;
        end
    end
endmodule

// File: rtl/seu_chain_harness.sv
module seu_chain_harness
    import seu_harness_pkg::*;
#(
    parameter int CHAIN_LEN = 16,
    parameter int CNT_W     = 32,
    parameter int TH_W      = 8,
    parameter int IDX_W     = $clog2(CHAIN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pat_sel,
    input  logic [TH_W-1:0]  burst_thresh,
    input  logic             inj_flip,
    input  logic [IDX_W-1:0] inj_idx,
    input  logic             inj_hold,
    input  logic             inj_double,
    output logic             err_pulse,
    output logic [CNT_W-1:0] err_count,
    output logic             burst_flag,
    output logic [CNT_W-1:0] burst_count
);
    logic       src_bit;
    logic       ref_bit;
    logic       chain_bit;
    shift_ctl_t ctl;

    assign ctl.hold = inj_hold;
    assign ctl.dbl  = inj_double && !inj_hold;

    seu_pattern_gen #(.CHAIN_LEN(CHAIN_LEN)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .pat_sel (pat_sel),
        .src_bit (src_bit),
        .ref_bit (ref_bit)
    );

    seu_shift_chain #(.CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .din      (src_bit),
        .ctl      (ctl),
        .flip     (inj_flip),
        .flip_idx (inj_idx),
        .dout     (chain_bit)
    );

    seu_mismatch_mon #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W), .TH_W(TH_W)) u_mon (
        .clk          (clk),
        .rst          (rst),
        .chain_bit    (chain_bit),
        .ref_bit      (ref_bit),
        .burst_thresh (burst_thresh),
        .err_pulse    (err_pulse),
        .err_count    (err_count),
        .burst_flag   (burst_flag),
        .burst_count  (burst_count)
    );
endmodule

// File: rtl/seu_chain_harness_chk.sv
module seu_chain_harness_chk #(
    parameter int CHAIN_LEN = 16,
    parameter int CNT_W     = 32,
    parameter int TH_W      = 8,
    parameter int IDX_W     = $clog2(CHAIN_LEN)
) (
    input logic             clk,
    input logic             rst,
    input logic             err_pulse,
    input logic [CNT_W-1:0] err_count,
    input logic             burst_flag,
    input logic [CNT_W-1:0] burst_count
);
    localparam int CYC_W = $clog2(CHAIN_LEN + 2) + 1;
    localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(CHAIN_LEN + 1);

    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)                 cyc_q <= '0;
        else if (cyc_q != CYC_TOP) cyc_q <= cyc_q + 1'b1;
    end

    // R2
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q < CYC_TOP) |-> !err_pulse);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> ((err_count != $past(err_count)) || (&err_count)));

    // R4
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> $stable(err_count));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (&$past(err_count)) |-> (&err_count));

    // R9
    burst_needs_err_chk: assert property (@(posedge clk) disable iff (rst)
        burst_flag |-> err_pulse);

    // R9
    burst_count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !burst_flag |-> $stable(burst_count));
endmodule

bind seu_chain_harness seu_chain_harness_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .CNT_W     (CNT_W),
    .TH_W      (TH_W),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/seu_chain_harness_bench.sv
module seu_chain_harness_bench;
    localparam int N     = 16;
    localparam int IDX_W = 4;
    localparam int TH_W  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       pat_sel = 2'b10;
    logic [TH_W-1:0]  burst_thresh = 8'd4;
    logic             inj_flip = 1'b0;
    logic [IDX_W-1:0] inj_idx = '0;
    logic             inj_hold = 1'b0;
    logic             inj_double = 1'b0;
    logic             err_pulse, burst_flag;
    logic [31:0]      err_count, burst_count;
    logic             s_pulse, s_flag;
    logic [3:0]       s_count, s_bcount;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int pulses, flags, maxrun, currun, first_j;

    always #10 clk = ~clk;

    seu_chain_harness u_seu_chain_harness (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .burst_thresh(burst_thresh),
        .inj_flip(inj_flip), .inj_idx(inj_idx), .inj_hold(inj_hold),
        .inj_double(inj_double), .err_pulse(err_pulse), .err_count(err_count),
        .burst_flag(burst_flag), .burst_count(burst_count)
    );

    seu_chain_harness #(.CNT_W(4)) u_sat (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .burst_thresh(burst_thresh),
        .inj_flip(inj_flip), .inj_idx(inj_idx), .inj_hold(inj_hold),
        .inj_double(inj_double), .err_pulse(s_pulse), .err_count(s_count),
        .burst_flag(s_flag), .burst_count(s_bcount)
    );

    function automatic int hold_errs(input logic [1:0] sel);
        return (sel[1]) ? N : 0;
    endfunction

    function automatic int dbl_errs(input logic [1:0] sel);
        return (sel[1]) ? N - 1 : 0;
    endfunction

    function automatic int flagged(input int run_len, input int th);
        return (run_len > th) ? run_len - th : 0;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel, input logic [TH_W-1:0] th);
        @(negedge clk);
        rst = 1'b1; pat_sel = sel; burst_thresh = th;
        inj_flip = 0; inj_hold = 0; inj_double = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Sample n falling edges; the first sample follows the edge that takes any injection.
    task automatic scan(input int n);
        pulses = 0; flags = 0; maxrun = 0; currun = 0; first_j = 0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (j == 1) begin inj_flip = 0; inj_hold = 0; inj_double = 0; end
            if (err_pulse) begin
                pulses++; currun++;
                if (first_j == 0) first_j = j;
                if (currun > maxrun) maxrun = currun;
            end else currun = 0;
            if (burst_flag) flags++;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] sel;
        int nflip, idx, rnd;
        rnd = $urandom(32'h5eed);

        // R10 reset state
        do_reset(2'b10, 8'd4);
        check("R10 err_count after reset", err_count, 0);
        check("R10 err_pulse after reset", err_pulse, 0);
        check("R10 burst_count after reset", burst_count, 0);

        // R2 warm-up window, R1 clean checkerboard
        scan(N);
        check("R2 pulses in warm-up", pulses, 0);
        scan(4 * N);
        check("R1 checkerboard clean run", err_count, 0);

        // R1 constant patterns clean
        for (int p = 0; p < 2; p++) begin
            do_reset(2'(p), 8'd4);
            scan(4 * N);
            check("R1 constant pattern clean run", err_count, 0);
        end

        // R3 R6 flip latency, constant ones at stage 5
        do_reset(2'b00, 8'd4);
        scan(2 * N);
        @(negedge clk); inj_flip = 1; inj_idx = 4'd5;
        scan(2 * N);
        check("R3 flip stage 5 latency", first_j, N - 5 + 1);
        check("R6 flip ones single error", err_count, 1);
        check("R3 one-cycle pulse", maxrun, 1);
        check("R6 no burst on flip", burst_count, 0);

        // R3 flip of the last and first stage, zeros
        do_reset(2'b01, 8'd4);
        scan(2 * N);
        @(negedge clk); inj_flip = 1; inj_idx = 4'd15;
        scan(2 * N);
        check("R3 flip last stage latency", first_j, 2);
        @(negedge clk); inj_flip = 1; inj_idx = 4'd0;
        scan(2 * N);
        check("R3 flip stage 0 latency", first_j, N + 1);
        check("R4 two flips counted", err_count, 2);

        // R7 R9 held shift on checkerboard, R5 on narrow instance
        do_reset(2'b10, 8'd4);
        scan(2 * N);
        @(negedge clk); inj_hold = 1;
        scan(3 * N);
        check("R7 hold errors", err_count, hold_errs(2'b10));
        check("R7 hold run length", maxrun, N);
        check("R9 hold flagged cycles", flags, flagged(N, 4));
        check("R9 hold burst count", burst_count, 1);
        check("R5 narrow count saturates", s_count, 15);

        // R7 doubled shift on checkerboard
        do_reset(2'b11, 8'd4);
        scan(2 * N);
        @(negedge clk); inj_double = 1;
        scan(3 * N);
        check("R7 double errors", err_count, dbl_errs(2'b11));
        check("R7 double run length", maxrun, N - 1);
        check("R9 double burst count", burst_count, 1);

        // R8 slips hidden by constant patterns
        do_reset(2'b00, 8'd4);
        scan(2 * N);
        @(negedge clk); inj_hold = 1;
        scan(2 * N);
        @(negedge clk); inj_double = 1;
        scan(2 * N);
        check("R8 ones slips", err_count, 0);
        do_reset(2'b01, 8'd4);
        scan(2 * N);
        @(negedge clk); inj_double = 1;
        scan(2 * N);
        check("R8 zeros slips", err_count, 0);

        // R9 zero threshold: isolated flip counts as a burst
        do_reset(2'b10, 8'd0);
        scan(2 * N);
        @(negedge clk); inj_flip = 1; inj_idx = 4'd9;
        scan(2 * N);
        check("R9 thresh 0 burst count", burst_count, 1);
        check("R9 thresh 0 flag cycles", flags, 1);

        // R9 threshold equal to burst length: no burst
        do_reset(2'b10, 8'd16);
        scan(2 * N);
        @(negedge clk); inj_hold = 1;
        scan(3 * N);
        check("R9 thresh equal length", burst_count, 0);

        // R6 R4 random isolated flips
        for (int r = 0; r < 6; r++) begin
            sel = 2'($urandom % 4);
            do_reset(sel, 8'(1 + $urandom % 3));
            scan(N + 2);
            nflip = 3 + $urandom % 5;
            for (int f = 0; f < nflip; f++) begin
                idx = $urandom % N;
                @(negedge clk); inj_flip = 1; inj_idx = 4'(idx);
                scan(N + 2);
                check("R3 random flip latency", first_j, N - idx + 1);
            end
            scan(N);
            check("R6 random flip count", err_count, nflip);
            check("R6 random no burst", burst_count, 0);
        end

        // R10 reset clears accumulated counts
        do_reset(2'b10, 8'd2);
        scan(2 * N);
        @(negedge clk); inj_hold = 1;
        scan(3 * N);
        do_reset(2'b10, 8'd2);
        check("R10 count cleared", err_count, 0);
        check("R10 burst cleared", burst_count, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule